// File: doc/BRIEF.md
# PWM Channel Interrupt Status Register

This block keeps the interrupt state of one channel in a ring of chained PWM power-stage controllers. The channel's timing core feeds it single-cycle strobes: completion of a whole PWM cycle, external event A, external event B, and the channel's own update. It also receives the run/update strobe of the preceding channel in the ring, plus the index of the ramp currently in progress. Each strobe sets a sticky flag. The ramp that was active at the latest external event is recorded in a read-only field. While auto-run is enabled, the block flags a synchronisation error whenever the channel's update and the predecessor's run strobe fail to arrive together.

Software reaches the block through a small register port with one select bit. Select 0 is the status word, where writing a 1 clears a flag. Select 1 is the per-flag enable word. The registered interrupt output is the OR of every flag gated by its enable. In a ring, channel 0 takes its predecessor strobe from the last channel, for example channel 2 in a ring of three. The integration wires the ring; this block sees only the one incoming strobe.

Top module: `pwm_irq_status`

## Requirements
- R1: In the cycle after synchronous reset, the status word, the enable word and `irq` all read 0.
- R2: A pulse on `eoc_stb` sets status bit 0, which reads 1 from the next clock edge onward.
- R3: A pulse on `eva_stb` sets status bit 3 and a pulse on `evb_stb` sets status bit 4, whatever the enable word holds.
- R4: Status bits 2:1 take the value of `ramp_idx` (0 = ramp 1, 1 = ramp 2, 2 = ramp 3, 3 = ramp 4) at every cycle with `eva_stb` or `evb_stb` high, and hold it in all other cycles.
- R5: The ramp field is read-only: a status write leaves bits 2:1 unchanged.
- R6: With `auto_run` high, a cycle in which exactly one of `upd_stb` and `pred_run_stb` is high sets status bit 5. With `auto_run` low, bit 5 is never set.
- R7: A status write clears every flag (bits 0, 3, 4, 5) whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Bits 7:6 always read 0.
- R8: When a flag's hardware set and its software clear fall in the same cycle, the flag ends up set.
- R9: The enable word (select 1) stores bits 0, 3, 4 and 5 as written. Its other bits read 0.
- R10: `irq` equals the OR over flags of (flag AND its enable), one cycle after the flag and enable values it reflects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_run | input | 1 | Channel runs from predecessor's run strobe; enables sync check |
| eoc_stb | input | 1 | End of whole PWM cycle strobe |
| eva_stb | input | 1 | External event A strobe |
| evb_stb | input | 1 | External event B strobe |
| upd_stb | input | 1 | This channel's update strobe |
| pred_run_stb | input | 1 | Run/update strobe of the preceding ring channel |
| ramp_idx | input | 2 | Current ramp, 0..3 for ramp 1..4 |
| reg_sel | input | 1 | 0 = status word, 1 = enable word |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected word (combinational) |
| irq | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that each strobe describes a single clock cycle. They also assume `auto_run`, `ramp_idx` and the register inputs hold steady in the cycle they are sampled, and that reset is asserted from time zero. The bench changes every input only on the falling clock edge and keeps reset high through the first edges, so each sampled value is settled. The sweeps cover every ramp index with each event source, every combination of `auto_run` and the two update strobes, and all sixteen enable patterns against each flag.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;

    localparam int REG_W   = 8;
    localparam int FLAG_N  = 4;
    localparam int RAMP_W  = 2;

    // Flag slots in the internal vector
    typedef enum logic [1:0] {
        FL_EOC  = 2'd0,
        FL_EVA  = 2'd1,
        FL_EVB  = 2'd2,
        FL_SYNC = 2'd3
    } flag_e;

    typedef struct packed {
        logic eoc;
        logic eva;
        logic evb;
        logic upd;
        logic pred_run;
    } strobe_t;

    // Bit position of each flag in the software-visible word
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input logic [FLAG_N-1:0] f,
                                                  input logic [RAMP_W-1:0] r);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < FLAG_N; i++) w[flag_pos(i)] = f[i];
        w[2:1] = r;
        return w;
    endfunction

    function automatic logic [FLAG_N-1:0] unpack_flags(input logic [REG_W-1:0] w);
        logic [FLAG_N-1:0] f;
        for (int i = 0; i < FLAG_N; i++) f[i] = w[flag_pos(i)];
        return f;
    endfunction

endpackage

// File: rtl/pwm_irq_flag.sv
module pwm_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/pwm_irq_ramp.sv
module pwm_irq_ramp #(
    parameter int RW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_i,
    input  logic [RW-1:0] ramp_i,
    output logic [RW-1:0] ramp_o
);
    always_ff @(posedge clk) begin
        if (rst)        ramp_o <= '0;
        else if (cap_i) ramp_o <= ramp_i;
    end

    assert_ramp_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(ramp_o));
    assert_ramp_cap_R4: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> (ramp_o == $past(ramp_i)));
endmodule

// File: rtl/pwm_irq_sync.sv
module pwm_irq_sync (
    input  logic clk,
    input  logic rst,
    input  logic auto_run_i,
    input  logic upd_i,
    input  logic pred_i,
    output logic err_o
);
    // Mismatch inside the single-cycle window counts as an error
    always_comb err_o = auto_run_i && (upd_i != pred_i);

    assert_no_err_manual_R6: assert property (@(posedge clk) disable iff (rst)
        !auto_run_i |-> !err_o);
    assert_match_ok_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_i == pred_i) |-> !err_o);
endmodule

// File: rtl/pwm_irq_status.sv
module pwm_irq_status
    import pwm_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_run,
    input  logic             eoc_stb,
    input  logic             eva_stb,
    input  logic             evb_stb,
    input  logic             upd_stb,
    input  logic             pred_run_stb,
    input  logic [RAMP_W-1:0] ramp_idx,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    strobe_t             stb;
    logic                sync_err;
    logic [FLAG_N-1:0]   set_vec;
    logic [FLAG_N-1:0]   clr_vec;
    logic [FLAG_N-1:0]   flags;
    logic [FLAG_N-1:0]   en_q;
    logic [RAMP_W-1:0]   ramp_q;
    logic [REG_W-1:0]    status_word;

    always_comb begin
        stb.eoc      = eoc_stb;
        stb.eva      = eva_stb;
        stb.evb      = evb_stb;
        stb.upd      = upd_stb;
        stb.pred_run = pred_run_stb;
    end

    pwm_irq_sync u_sync (
        .clk(clk), .rst(rst), .auto_run_i(auto_run),
        .upd_i(stb.upd), .pred_i(stb.pred_run), .err_o(sync_err)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[FL_EOC]  = stb.eoc;
        set_vec[FL_EVA]  = stb.eva;
        set_vec[FL_EVB]  = stb.evb;
        set_vec[FL_SYNC] = sync_err;
        clr_vec = (reg_wr && !reg_sel) ? unpack_flags(reg_wdata) : '0;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        pwm_irq_flag u_flag (
            .clk(clk), .rst(rst),
            .set_i(set_vec[i]), .clr_i(clr_vec[i]), .q_o(flags[i])
        );
    end

    pwm_irq_ramp #(.RW(RAMP_W)) u_ramp (
        .clk(clk), .rst(rst),
        .cap_i(stb.eva | stb.evb), .ramp_i(ramp_idx), .ramp_o(ramp_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                    en_q <= '0;
        else if (reg_wr && reg_sel) en_q <= unpack_flags(reg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(flags & en_q);
    end

    always_comb begin
        status_word = pack_word(flags, ramp_q);
        reg_rdata   = reg_sel ? pack_word(en_q, '0) : status_word;
    end

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(flags & en_q))));
    assert_top_zero_R7: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7:6] == 2'b00);
    assert_eva_sets_R3: assert property (@(posedge clk) disable iff (rst)
        eva_stb |=> reg_rdata[3] || reg_sel);
    assert_eoc_sets_R2: assert property (@(posedge clk) disable iff (rst)
        eoc_stb |=> flags[FL_EOC]);
endmodule

// File: tb/pwm_irq_status_test.sv
module pwm_irq_status_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic auto_run = 0, eoc_stb = 0, eva_stb = 0, evb_stb = 0, upd_stb = 0, pred_run_stb = 0;
    logic [1:0] ramp_idx = 0;
    logic reg_sel = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic irq;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_irq_status uut (
        .clk(clk), .rst(rst), .auto_run(auto_run), .eoc_stb(eoc_stb),
        .eva_stb(eva_stb), .evb_stb(evb_stb), .upd_stb(upd_stb),
        .pred_run_stb(pred_run_stb), .ramp_idx(ramp_idx), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wr = 1; reg_wdata = d;
        cyc();
        reg_wr = 0; reg_sel = 0;
    endtask

    task automatic clear_all();
        wr(0, 8'hFF);
    endtask

    task automatic read_status(output logic [7:0] v);
        reg_sel = 0; #1 v = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [1:0] rsave;
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        read_status(v); check("R1 status", v, 8'h00);
        reg_sel = 1; #1 check("R1 enable", reg_rdata, 8'h00); reg_sel = 0;
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R2 end of cycle
        eoc_stb = 1; cyc(); eoc_stb = 0;
        read_status(v); check("R2 eoc", v & 8'h01, 8'h01);
        clear_all();

        // R3/R4 ramp sweep over each source with enables off
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 3; s++) begin
                ramp_idx = r[1:0];
                eva_stb = (s != 1); evb_stb = (s != 0);
                cyc(); eva_stb = 0; evb_stb = 0;
                read_status(v);
                check("R3 event flags", v & 8'h18,
                      {3'b0, (s != 0), (s != 1), 3'b0});
                check("R4 ramp capture", {6'b0, v[2:1]}, {6'b0, r[1:0]});
                clear_all();
            end
        end
        // R4 hold without event
        rsave = 2'd2; ramp_idx = rsave; eva_stb = 1; cyc(); eva_stb = 0;
        ramp_idx = 2'd1; repeat (2) cyc();
        read_status(v); check("R4 ramp hold", {6'b0, v[2:1]}, 8'd2);

        // R5 and R7: full-ones write clears flags, ramp stays
        eoc_stb = 1; evb_stb = 1; ramp_idx = 2'd3; cyc(); eoc_stb = 0; evb_stb = 0;
        wr(0, 8'hFF);
        read_status(v); check("R5 ramp read-only", v, 8'h06);
        // R7 write of zero keeps flags
        eoc_stb = 1; eva_stb = 1; ramp_idx = 2'd0; cyc(); eoc_stb = 0; eva_stb = 0;
        wr(0, 8'h00);
        read_status(v); check("R7 zero write", v, 8'h09);
        wr(0, 8'h01);
        read_status(v); check("R7 partial clear", v, 8'h08);
        wr(0, 8'hC0);
        read_status(v); check("R7 top bits", v, 8'h08);
        clear_all();

        // R8 set beats clear
        eoc_stb = 1; reg_sel = 0; reg_wr = 1; reg_wdata = 8'h01;
        cyc(); eoc_stb = 0; reg_wr = 0;
        read_status(v); check("R8 set priority", v & 8'h01, 8'h01);
        clear_all();

        // R6 sync sweep
        for (int k = 0; k < 8; k++) begin
            auto_run = k[2]; upd_stb = k[1]; pred_run_stb = k[0];
            cyc(); upd_stb = 0; pred_run_stb = 0;
            read_status(v);
            check("R6 sync error", v & 8'h20,
                  (k[2] && (k[1] != k[0])) ? 8'h20 : 8'h00);
            clear_all();
        end
        auto_run = 0;

        // R9 enable register
        wr(1, 8'hFF); reg_sel = 1; #1 check("R9 enable mask", reg_rdata, 8'h39);
        wr(1, 8'h11); reg_sel = 1; #1 check("R9 enable write", reg_rdata, 8'h11);
        reg_sel = 0;

        // R10 enable x flag sweep
        for (int e = 0; e < 16; e++) begin
            wr(1, {2'b0, e[3], e[2], e[1], 2'b0, e[0]});
            for (int f = 0; f < 4; f++) begin
                clear_all(); cyc();
                check("R10 irq idle", {7'b0, irq}, 8'h00);
                auto_run = (f == 3);
                eoc_stb = (f == 0); eva_stb = (f == 1); evb_stb = (f == 2);
                upd_stb = (f == 3);
                cyc();
                eoc_stb = 0; eva_stb = 0; evb_stb = 0; upd_stb = 0; auto_run = 0;
                cyc();
                check("R10 irq", {7'b0, irq}, {7'b0, e[f]});
            end
        end
        clear_all(); cyc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule